// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast source clock into the two timing strobes a serial line engine needs. One is an oversampling strobe that runs at sixteen times the line rate. The other is a bit strobe that runs at the line rate. The line period is set by a divisor with an integer part and a four-bit fraction in sixteenths of a source clock. An 8-bit prescaler slows the source clock by (count + 1) before the divisor is applied, which is how low line rates are reached.

The fraction is not applied once per bit. An accumulator spreads it over the sixteen oversampling periods of each bit. Each oversampling period is therefore a whole number of prescaled clocks, and the long-run bit period equals the programmed value exactly.

Divisor and prescaler inputs are captured into shadow copies. While the block is disabled, the copies follow the inputs. While it is running, they change only at a bit boundary. The serializer that consumes the strobes and any clock source selection sit outside this block.

Top module: `frac_baud_gen`

## Requirements
- R1: While `enable` is low (and during reset), both `osTick` and `bitTick` stay low, and all counters are held at zero.
- R2: The prescaler produces one internal count pulse every (`preDiv` + 1) source clocks, and every tick period scales with it.
- R3: Define V = {`divInt`, `divFrac`} as a value in sixteenths of a clock. Counting edges from the last edge at which the block was disabled (or restarted), the k-th `osTick` (k ≥ 1) is high in the cycle after edge (`preDiv`+1)·floor(k·V/256).
- R4: `bitTick` is high exactly on every 16th `osTick` (k = 16, 32, ...), so the average bit period is (`preDiv`+1)·V/16 source clocks.
- R5: Each oversampling period lasts either floor(V/256) or floor(V/256)+1 prescaled clocks, with the extra clock placed by an 8-bit accumulator.
- R6: A V below 256 (integer divisor under 16) is treated as exactly 256, so the fastest bit rate is the prescaled clock divided by 16.
- R7: While running, changes to `divInt`, `divFrac` or `preDiv` have no effect until the next `bitTick` edge. At that edge, differing inputs are captured, the fraction accumulator is cleared, and timing restarts from that edge as in R3.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low holds everything at zero |
| divInt | input | 20 | Integer part of the bit divisor |
| divFrac | input | 4 | Fractional part of the bit divisor, in sixteenths |
| preDiv | input | 8 | Prescaler count; source clock divided by this + 1 |
| osTick | output | 1 | One-cycle strobe at 16x the bit rate |
| bitTick | output | 1 | One-cycle strobe at the bit rate |

## Verification
Three events can fall on one clock edge: the sixteenth oversampling strobe closes a bit, the fraction accumulator either carries or is cleared, and a pending divisor change is captured. The bench provokes this by rewriting the divisor and prescaler partway through a bit, both in directed cases and at random points. It then predicts the next strobes from the closed-form R3 schedule. Before the boundary the old setting is used. From the boundary edge the new setting is used with a fresh count, so any early capture or missed accumulator clear shows up as a tick one clock off.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic hold;     // block disabled: clear counters, track inputs
    logic bitEdge;  // this edge closes a bit period
  } baudCtl_t;

endpackage

// File: rtl/frac_baud_dp.sv
module frac_baud_dp
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int FRAC_W = 4,
  parameter int PRE_W  = 8,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [PRE_W-1:0]  preDiv,
  input  baudCtl_t          ctl,
  output logic              osPulse
);

  localparam int VW = DIV_W + FRAC_W;   // full divisor width in sixteenths
  localparam int AW = FRAC_W + SUB_W;   // oversample fraction width
  localparam int IW = VW - AW;          // oversample integer width
  localparam logic [VW-1:0] V_MIN = {{(VW-1){1'b0}}, 1'b1} << AW;

  logic [DIV_W-1:0]  divS;
  logic [FRAC_W-1:0] fracS;
  logic [PRE_W-1:0]  preS;
  logic [PRE_W-1:0]  preCnt;
  logic [IW-1:0]     osCnt;
  logic [AW-1:0]     acc;

  logic [VW-1:0] rawV, effV;
  logic [IW-1:0] osInt;
  logic [AW-1:0] osFrac;
  logic [AW:0]   accSum;
  logic          carry;
  logic [IW:0]   lenNow, cntNext;
  logic          srcEn, cfgDiff;

  always_comb begin
    rawV    = {divS, fracS};
    effV    = (rawV < V_MIN) ? V_MIN : rawV;
    osInt   = effV[VW-1:AW];
    osFrac  = effV[AW-1:0];
    accSum  = {1'b0, acc} + {1'b0, osFrac};
    carry   = accSum[AW];
    lenNow  = {1'b0, osInt} + {{IW{1'b0}}, carry};
    cntNext = {1'b0, osCnt} + {{IW{1'b0}}, 1'b1};
    srcEn   = !ctl.hold && (preCnt == preS);
    osPulse = srcEn && (cntNext == lenNow);
    cfgDiff = {divInt, divFrac, preDiv} != {divS, fracS, preS};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divS   <= '0;
      fracS  <= '0;
      preS   <= '0;
      preCnt <= '0;
      osCnt  <= '0;
      acc    <= '0;
    end else if (ctl.hold) begin
      divS   <= divInt;
      fracS  <= divFrac;
      preS   <= preDiv;
      preCnt <= '0;
      osCnt  <= '0;
      acc    <= '0;
    end else begin
      preCnt <= srcEn ? '0 : preCnt + 1'b1;
      if (srcEn) osCnt <= osPulse ? '0 : cntNext[IW-1:0];
      if (osPulse) acc <= accSum[AW-1:0];
      if (ctl.bitEdge && cfgDiff) begin
        divS  <= divInt;
        fracS <= divFrac;
        preS  <= preDiv;
        acc   <= '0;
      end
    end
  end

  // R2: prescaler never runs past its terminal count
  a_r2_pre_in_range: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preS);

  // R5: a period never exceeds the integer part plus one carry clock
  a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rstN)
    osCnt <= osInt);

  // R7: captured settings only move at a bit boundary while running
  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.hold && !ctl.bitEdge) |=> $stable({divS, fracS, preS}));

endmodule

// File: rtl/frac_baud_ctl.sv
module frac_baud_ctl
  import frac_baud_pkg::*;
#(
  parameter int SUB_W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     osPulse,
  output baudCtl_t ctl
);

  logic [SUB_W-1:0] subCnt;

  always_comb begin
    ctl.hold    = !enable;
    ctl.bitEdge = osPulse && (subCnt == {SUB_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) subCnt <= '0;
    else if (osPulse)     subCnt <= subCnt + 1'b1;
  end

  // R1: disabling clears the sub-period position
  a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (subCnt == '0));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int FRAC_W = 4,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [PRE_W-1:0]  preDiv,
  output logic              osTick,
  output logic              bitTick
);

  localparam int SUB_W = 4;  // 16 oversample periods per bit

  baudCtl_t ctl;
  logic     osPulse;

  frac_baud_dp #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W), .SUB_W(SUB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .divInt(divInt), .divFrac(divFrac),
    .preDiv(preDiv), .ctl(ctl), .osPulse(osPulse)
  );

  frac_baud_ctl #(.SUB_W(SUB_W)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .osPulse(osPulse), .ctl(ctl)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      osTick  <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      osTick  <= osPulse;
      bitTick <= ctl.bitEdge;
    end
  end

  // R1: nothing is issued the cycle after enable is low
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!osTick && !bitTick));

  // R4: every bit strobe coincides with an oversample strobe
  a_r4_bit_on_os: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> osTick);

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [19:0] divInt = 20'd16;
  logic [3:0]  divFrac = 4'd0;
  logic [7:0]  preDiv = 8'd0;
  logic        osTick, bitTick;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  longint actDiv, actFrac, actPre;
  longint cnt, k, nextEdge;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divInt(divInt),
    .divFrac(divFrac), .preDiv(preDiv), .osTick(osTick), .bitTick(bitTick)
  );

  function automatic longint effV(longint d, longint f);
    longint v = d * 16 + f;
    return (v < 256) ? 256 : v;
  endfunction

  function automatic longint tickEdge(longint kk, longint d, longint f, longint p);
    return (p + 1) * ((kk * effV(d, f)) / 256);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic restartModel();
    actDiv = divInt; actFrac = divFrac; actPre = preDiv;
    cnt = 0; k = 1;
    nextEdge = tickEdge(k, actDiv, actFrac, actPre);
  endtask

  task automatic runCycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rstN || !enable) begin
        chk(osTick, 1'b0, "R1 osTick");
        chk(bitTick, 1'b0, "R1 bitTick");
        restartModel();
      end else begin
        logic expOs, expBit;
        cnt++;
        expOs  = (cnt == nextEdge);
        expBit = expOs && ((k % 16) == 0);
        chk(osTick, expOs, tag);
        chk(bitTick, expBit, "R4 bitTick");
        if (expOs) begin
          if (expBit && (divInt != actDiv || divFrac != actFrac || preDiv != actPre))
            restartModel();   // R7 capture at boundary
          else begin
            k++;
            nextEdge = tickEdge(k, actDiv, actFrac, actPre);
          end
        end
      end
    end
  endtask

  task automatic setCfg(input int d, input int f, input int p);
    divInt = 20'(d); divFrac = 4'(f); preDiv = 8'(p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    restartModel();
    // R1: reset state
    runCycles(4, "R1");
    @(negedge clk) rstN = 1'b1;
    runCycles(3, "R1");
    // R3: fastest setting, tick every clock
    setCfg(16, 0, 0);
    runCycles(1, "R1");
    enable = 1'b1;
    runCycles(100, "R3 osTick");
    enable = 1'b0;
    runCycles(5, "R1");
    // R5: fractional spreading
    setCfg(20, 5, 0);
    runCycles(2, "R1");
    enable = 1'b1;
    runCycles(1000, "R5 osTick");
    enable = 1'b0;
    // R2: prescaler
    setCfg(17, 9, 3);
    runCycles(2, "R1");
    enable = 1'b1;
    runCycles(2000, "R2 osTick");
    enable = 1'b0;
    // R6: clamp below 16
    setCfg(5, 3, 1);
    runCycles(2, "R1");
    enable = 1'b1;
    runCycles(300, "R6 osTick");
    enable = 1'b0;
    // R7: mid-bit change, applied at the boundary
    setCfg(40, 0, 0);
    runCycles(2, "R1");
    enable = 1'b1;
    runCycles(100, "R7 osTick");
    setCfg(23, 11, 0);
    runCycles(2000, "R7 osTick");
    enable = 1'b0;
    // R2: largest prescaler
    setCfg(16, 0, 255);
    runCycles(2, "R1");
    enable = 1'b1;
    runCycles(9000, "R2 osTick");
    enable = 1'b0;
    // random mix
    for (int it = 0; it < 10; it++) begin
      setCfg(16 + ($urandom % 135), $urandom % 16, $urandom % 4);
      runCycles(2, "R1");
      enable = 1'b1;
      runCycles(200 + ($urandom % 800), "R3 osTick");
      if ($urandom % 2) begin
        setCfg(($urandom % 90), $urandom % 16, $urandom % 3);
        runCycles(1500, "R7 osTick");
      end
      enable = 1'b0;
      runCycles(3, "R1");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule